// File: doc/BRIEF.md
# Clock Source and Shared-Pin Router

This block sits between the package pins of a programmable logic device and its internal clock and control nets. Three dedicated clock pins and one clock produced by a designated clock logic block are routed onto five clock lines. Three of those lines feed the logic blocks and two feed the I/O cells. The first logic-block line is hard-wired to clock pin 0. Each of the other four lines carries a 2-bit source selection taken from configuration.

The same block also decodes the pins that have two jobs. Clock pin 1 can be configured to act as the active-low global clear for every logic-block and I/O register. An active-low programming enable switches four pins between two roles. In user mode they are three dedicated inputs and a clock. In programming mode they are serial data in, mode control, serial data out and shift clock. In programming mode the block turns on the data-out driver and blocks the shift clock from every user clock line.

The block is purely combinational. No register sits between a pin and its internal net, so the added delay is only a mux level.

Top module: `clkpin_net`

## Requirements
- R1: `glb_clk[0]` equals `pin_y0` at all times, whatever the configuration and mode.
- R2: Each selected line takes its 2-bit field of `clk_sel`. The fields are `[1:0]` for `glb_clk[1]`, `[3:2]` for `glb_clk[2]`, `[5:4]` for `io_clk[0]` and `[7:6]` for `io_clk[1]`. The codes are 00 = clock pin 1, 01 = clock pin 2, 10 = internal clock and 11 = constant 0.
- R3: While `prog_en_n` is 0, every line whose field is 01 outputs 0.
- R4: When `y1_rst_en` is 1, `gl_rst_n` equals `pin_y1`. When `y1_rst_en` is 0, `gl_rst_n` is 1.
- R5: When `y1_rst_en` is 1, every line whose field is 00 outputs 0.
- R6: While `prog_en_n` is 0, the outputs `prog_sdi`, `prog_mode` and `prog_sclk` follow `pin_sdi`, `pin_mode` and `pin_y2`. While `prog_en_n` is 1, all three are 0.
- R7: While `prog_en_n` is 1, `ded_in[0]`, `ded_in[1]` and `ded_in[2]` follow `pin_sdi`, `pin_sdo_in` and `pin_mode`. While `prog_en_n` is 0, all three are 0.
- R8: `sdo_oe` is the inverse of `prog_en_n`. `sdo_out` equals `shift_dout` while `sdo_oe` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_y0 | input | 1 | Clock pin 0 |
| pin_y1 | input | 1 | Clock pin 1, also the global clear when enabled |
| pin_y2 | input | 1 | Clock pin 2, also the shift clock in programming mode |
| int_clk | input | 1 | Clock from the designated clock logic block |
| prog_en_n | input | 1 | Programming enable, active low |
| y1_rst_en | input | 1 | Configuration: clock pin 1 acts as the global clear |
| clk_sel | input | 8 | Four 2-bit source selections |
| pin_sdi | input | 1 | Shared pin: serial data in or dedicated input 0 |
| pin_mode | input | 1 | Shared pin: mode control or dedicated input 2 |
| pin_sdo_in | input | 1 | Input side of the shared data-out pin |
| shift_dout | input | 1 | Shift-register data from the programming logic |
| glb_clk | output | 3 | Clock lines to the logic blocks |
| io_clk | output | 2 | Clock lines to the I/O cells |
| gl_rst_n | output | 1 | Global asynchronous clear, active low |
| prog_sdi | output | 1 | Serial data to the programming logic |
| prog_mode | output | 1 | Mode control to the programming logic |
| prog_sclk | output | 1 | Shift clock to the programming logic |
| sdo_out | output | 1 | Output value for the shared data-out pin |
| sdo_oe | output | 1 | Output enable for the shared data-out pin |
| ded_in | output | 3 | Dedicated user inputs |

## Verification
The in-line assertions check the following after every input change:
- the fixed route of clock pin 0;
- the blocking of the shift clock from user lines in programming mode;
- the blocking of clock pin 1 when it is configured as a clear;
- the polarity of the reset and of the data-out driver;
- the idle level of every shared-pin output in the mode where it is not used.

The bench alone can show the full selection code table on each of the four selectable lines, including which field steers which line. It sweeps every value of `clk_sel` against every combination of clock pins, internal clock, mode and reset configuration.

// File: rtl/clkpin_net.sv
module clkpin_net #(
  parameter int SEL_W  = 2,
  parameter int N_GLB  = 3,
  parameter int N_IO   = 2,
  localparam int N_SEL = N_GLB - 1 + N_IO,
  localparam int CFG_W = SEL_W * N_SEL
) (
  input  logic             pin_y0,
  input  logic             pin_y1,
  input  logic             pin_y2,
  input  logic             int_clk,
  input  logic             prog_en_n,
  input  logic             y1_rst_en,
  input  logic [CFG_W-1:0] clk_sel,
  input  logic             pin_sdi,
  input  logic             pin_mode,
  input  logic             pin_sdo_in,
  input  logic             shift_dout,
  output logic [N_GLB-1:0] glb_clk,
  output logic [N_IO-1:0]  io_clk,
  output logic             gl_rst_n,
  output logic             prog_sdi,
  output logic             prog_mode,
  output logic             prog_sclk,
  output logic             sdo_out,
  output logic             sdo_oe,
  output logic [2:0]       ded_in
);

  logic user_mode;
  logic src_y1, src_y2;
  logic [N_SEL-1:0] sel_clk;

  assign user_mode = prog_en_n;
  assign src_y1    = pin_y1 & ~y1_rst_en;
  assign src_y2    = pin_y2 & user_mode;

  for (genvar g = 0; g < N_SEL; g++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = clk_sel[g*SEL_W +: SEL_W];
    always_comb begin
      case (code)
        2'b00:   sel_clk[g] = src_y1;
        2'b01:   sel_clk[g] = src_y2;
        2'b10:   sel_clk[g] = int_clk;
        default: sel_clk[g] = 1'b0;
      endcase
    end

    always_comb begin
      // R3
      if (!prog_en_n && code == 2'b01)
        sclk_block_chk: assert (sel_clk[g] == 1'b0);
      // R5
      if (y1_rst_en && code == 2'b00)
        rst_pin_block_chk: assert (sel_clk[g] == 1'b0);
    end
  end

  assign glb_clk  = {sel_clk[N_GLB-2:0], pin_y0};
  assign io_clk   = sel_clk[N_SEL-1:N_GLB-1];

  assign gl_rst_n = y1_rst_en ? pin_y1 : 1'b1;

  assign prog_sdi  = pin_sdi  & ~user_mode;
  assign prog_mode = pin_mode & ~user_mode;
  assign prog_sclk = pin_y2   & ~user_mode;

  assign sdo_oe  = ~user_mode;
  assign sdo_out = shift_dout & ~user_mode;

  assign ded_in = {pin_mode, pin_sdo_in, pin_sdi} & {3{user_mode}};

  always_comb begin
    // R1
    y0_route_chk: assert (glb_clk[0] == pin_y0);
    // R4
    if (!y1_rst_en)
      rst_idle_chk: assert (gl_rst_n == 1'b1);
    // R6
    if (prog_en_n)
      prog_idle_chk: assert ({prog_sdi, prog_mode, prog_sclk} == 3'b000);
    // R7
    if (!prog_en_n)
      ded_idle_chk: assert (ded_in == 3'b000);
    // R8
    sdo_dir_chk: assert (sdo_oe != prog_en_n);
  end

endmodule

// File: tb/clkpin_net_tb.sv
module clkpin_net_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pin_y0, pin_y1, pin_y2, int_clk, prog_en_n, y1_rst_en;
  logic [7:0] clk_sel;
  logic pin_sdi, pin_mode, pin_sdo_in, shift_dout;
  logic [2:0] glb_clk;
  logic [1:0] io_clk;
  logic gl_rst_n, prog_sdi, prog_mode, prog_sclk, sdo_out, sdo_oe;
  logic [2:0] ded_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  clkpin_net u_dut (
    .pin_y0(pin_y0), .pin_y1(pin_y1), .pin_y2(pin_y2), .int_clk(int_clk),
    .prog_en_n(prog_en_n), .y1_rst_en(y1_rst_en), .clk_sel(clk_sel),
    .pin_sdi(pin_sdi), .pin_mode(pin_mode), .pin_sdo_in(pin_sdo_in),
    .shift_dout(shift_dout), .glb_clk(glb_clk), .io_clk(io_clk),
    .gl_rst_n(gl_rst_n), .prog_sdi(prog_sdi), .prog_mode(prog_mode),
    .prog_sclk(prog_sclk), .sdo_out(sdo_out), .sdo_oe(sdo_oe), .ded_in(ded_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (sel=%0h y=%b%b%b ic=%b pn=%b re=%b)",
               req, act, exp, clk_sel, pin_y2, pin_y1, pin_y0, int_clk, prog_en_n, y1_rst_en);
    end
  endtask

  function automatic logic line_exp(input logic [1:0] code, input logic y1, input logic y2,
                                    input logic ic, input logic pn, input logic re);
    case (code)
      2'd0:    return re ? 1'b0 : y1;
      2'd1:    return pn ? y2 : 1'b0;
      2'd2:    return ic;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pin_y0 = 0; pin_y1 = 0; pin_y2 = 0; int_clk = 0; prog_en_n = 1; y1_rst_en = 1;
    clk_sel = 8'hFF; pin_sdi = 0; pin_mode = 0; pin_sdo_in = 0; shift_dout = 0;
    @(negedge clk);
    // R4: clear asserted while clock pin 1 is low
    chk("R4 reset low", {7'd0, gl_rst_n}, 8'd0);
    chk("R2 const0", {6'd0, io_clk}, 8'd0);
    chk("R8 idle oe", {7'd0, sdo_oe}, 8'd0);

    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int v = 0; v < 64; v++) begin
        @(negedge clk);
        clk_sel    = cfg[7:0];
        pin_y0     = v[0];
        pin_y1     = v[1];
        pin_y2     = v[2];
        int_clk    = v[3];
        prog_en_n  = v[4];
        y1_rst_en  = v[5];
        pin_sdi    = v[0] ^ cfg[0];
        pin_mode   = v[1] ^ cfg[1];
        pin_sdo_in = v[2] ^ cfg[2];
        shift_dout = v[3] ^ cfg[3];
        #1;
        begin
          logic [3:0] e;
          for (int k = 0; k < 4; k++)
            e[k] = line_exp(clk_sel[2*k +: 2], pin_y1, pin_y2, int_clk, prog_en_n, y1_rst_en);
          // R1
          chk("R1 y0 route", {7'd0, glb_clk[0]}, {7'd0, pin_y0});
          // R2 R3 R5
          chk("R2/R3/R5 lines", {4'd0, io_clk, glb_clk[2:1]}, {4'd0, e});
          // R4
          chk("R4 reset", {7'd0, gl_rst_n}, {7'd0, y1_rst_en ? pin_y1 : 1'b1});
          // R6
          chk("R6 prog pins", {5'd0, prog_sdi, prog_mode, prog_sclk},
              prog_en_n ? 8'd0 : {5'd0, pin_sdi, pin_mode, pin_y2});
          // R7
          chk("R7 ded inputs", {5'd0, ded_in},
              prog_en_n ? {5'd0, pin_mode, pin_sdo_in, pin_sdi} : 8'd0);
          // R8
          chk("R8 sdo", {6'd0, sdo_oe, sdo_out},
              {6'd0, ~prog_en_n, shift_dout & ~prog_en_n});
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule